// File: doc/BRIEF.md
# SPI Flash Opcode Dispatch Parser

This block sits behind the serial shifter of an SPI flash-emulation device and looks at the first byte of each transaction, the opcode. It compares that byte against a programmable table of command slots, each holding a valid bit and an opcode. From the slot that matches and the current device mode, it picks exactly one downstream datapath to serve the rest of the transaction. That datapath can be a status read, an ID read, a discovery-table read, a generic read, an upload, a 4-byte address enable or exit, or a write enable or disable. The select is held until chip-select deasserts, and then the block re-arms.

Slot roles are fixed by index, and software programs only the opcodes. In flash mode the device serves status, ID and discovery reads itself. In passthrough mode it serves each of them only when that command's intercept enable is set. Otherwise no datapath is selected and the command flows through untouched. In any other mode the block ignores all bytes. The table entry that matched is captured when the opcode is accepted and is presented to the datapaths for the whole transaction.

Top module: `opcode_dispatch`

## Requirements
- R1: After asynchronous reset (rst_ni low), dp_sel_o is 0, addr4b_en_o is 0, entry_valid_o is 0 and entry_opcode_o is 0.
- R2: A slot matches a byte only when its valid bit is 1 and its opcode equals the byte. A slot with an equal opcode but a clear valid bit never matches, and a later matching slot is used instead.
- R3: Slot roles with default parameters are: 0..2 status, 3 ID, 4 discovery, 5..9 generic read, 10..11 upload, 12 enable 4B, 13 exit 4B, 14 write enable, 15 write disable. When several slots match, the lowest index wins.
- R4: The block is active only for mode_i 2'b01 (flash) or 2'b10 (passthrough). For 2'b00 and 2'b11, bytes are ignored, dp_sel_o stays 0 and the latched entry is unchanged.
- R5: In flash mode a matched status, ID or discovery opcode selects dp_sel_o bit 0, 1 or 2 respectively, one cycle after the byte is accepted.
- R6: In passthrough mode a status, ID or discovery opcode selects its bit only when icpt_status_i, icpt_id_i or icpt_disc_i respectively is 1. Otherwise dp_sel_o stays 0 for the transaction.
- R7: A generic read slot selects bit 3 and an upload slot selects bit 4, in either active mode.
- R8: An enable-4B slot selects bit 5 and raises addr4b_en_o. An exit-4B slot selects bit 6 and leaves addr4b_en_o at 0.
- R9: A write-enable slot selects bit 7 and a write-disable slot selects bit 8.
- R10: Only the first valid byte after sel_n_i falls is decoded. Later bytes, bytes after an unmatched opcode (which selects nothing), and bytes while sel_n_i is high leave dp_sel_o unchanged.
- R11: On the accepted first byte, entry_valid_o and entry_opcode_o take the matched slot's valid bit and opcode, or 0 and 0 when nothing matches. They hold that value until the next accepted first byte.
- R12: At most one dp_sel_o bit is 1 at any time. The select holds while sel_n_i is low, and both dp_sel_o and addr4b_en_o clear one cycle after sel_n_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Active-low chip-select; high ends the transaction |
| byte_valid_i | input | 1 | Strobe marking a received byte |
| byte_i | input | OP_W | Received byte |
| mode_i | input | 2 | 01 flash, 10 passthrough, others inactive |
| icpt_status_i | input | 1 | Serve status reads locally in passthrough |
| icpt_id_i | input | 1 | Serve ID reads locally in passthrough |
| icpt_disc_i | input | 1 | Serve discovery reads locally in passthrough |
| slot_valid_i | input | NUM_SLOTS | Valid bit per table slot |
| slot_opcode_i | input | NUM_SLOTS*OP_W | Opcode per slot, slot i at bits i*OP_W upward |
| dp_sel_o | output | 9 | One-hot datapath select |
| addr4b_en_o | output | 1 | High for a 4-byte enable, low for exit or anything else |
| entry_valid_o | output | 1 | Latched valid bit of the matched slot |
| entry_opcode_o | output | OP_W | Latched opcode of the matched slot |

## Verification
On every cycle the assertions cover several properties: the one-hot shape of the select, its clearing on deselect, its hold for the rest of a transaction, its silence in inactive modes, the tie between the 4B flag and the enable datapath, and the stability of the latched entry once a datapath is chosen. Which datapath a given opcode should reach is a different matter. It depends on slot priority, mode and the intercept enables, and only the bench sweeps can show it. Those sweeps cover every slot and an unmatched byte under all four mode codes and all intercept combinations. They also cover duplicate opcodes and slots with a clear valid bit.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_STATUS, ST_ID, ST_DISC, ST_READ,
    ST_UPLOAD, ST_ADDR4B, ST_WREN, ST_WAIT
  } disp_state_e;

  localparam int DP_STATUS = 0;
  localparam int DP_ID     = 1;
  localparam int DP_DISC   = 2;
  localparam int DP_READ   = 3;
  localparam int DP_UPLOAD = 4;
  localparam int DP_EN4B   = 5;
  localparam int DP_EX4B   = 6;
  localparam int DP_WREN   = 7;
  localparam int DP_WRDI   = 8;
  localparam int DP_W      = 9;

  localparam logic [1:0] MODE_FLASH = 2'b01;
  localparam logic [1:0] MODE_PASS  = 2'b10;

  localparam int FIXED_LO_SLOTS = 5;  // status x3, id, disc
  localparam int FIXED_HI_SLOTS = 4;  // en4b, ex4b, wren, wrdi
endpackage

// File: rtl/slot_match.sv
module slot_match #(
  parameter int NUM_SLOTS = 16,
  parameter int OP_W      = 8,
  parameter int IDX_W     = 4
) (
  input  logic [NUM_SLOTS-1:0]      slot_valid_i,
  input  logic [NUM_SLOTS*OP_W-1:0] slot_opcode_i,
  input  logic [OP_W-1:0]           byte_i,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [OP_W-1:0]           opcode_o
);
  logic [NUM_SLOTS-1:0] eq;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign eq[g] = slot_valid_i[g] && (slot_opcode_i[g*OP_W +: OP_W] == byte_i);
  end

  // lowest index wins
  always_comb begin
    hit_o    = 1'b0;
    idx_o    = '0;
    opcode_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit_o    = 1'b1;
        idx_o    = IDX_W'(i);
        opcode_o = slot_opcode_i[i*OP_W +: OP_W];
      end
    end
  end
endmodule

// File: rtl/dispatch_fsm.sv
module dispatch_fsm
  import dispatch_pkg::*;
#(
  parameter int NUM_READ   = 5,
  parameter int NUM_UPLOAD = 2,
  parameter int IDX_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_n_i,
  input  logic              byte_valid_i,
  input  logic [1:0]        mode_i,
  input  logic              icpt_status_i,
  input  logic              icpt_id_i,
  input  logic              icpt_disc_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              accept_o,
  output logic [DP_W-1:0]   dp_sel_o,
  output logic              addr4b_en_o
);
  localparam int STATUS_HI = 2;
  localparam int ID_IDX    = 3;
  localparam int DISC_IDX  = 4;
  localparam int READ_LO   = FIXED_LO_SLOTS;
  localparam int READ_HI   = READ_LO + NUM_READ - 1;
  localparam int UP_LO     = READ_HI + 1;
  localparam int UP_HI     = UP_LO + NUM_UPLOAD - 1;
  localparam int EN4B_IDX  = UP_HI + 1;
  localparam int EX4B_IDX  = UP_HI + 2;
  localparam int WREN_IDX  = UP_HI + 3;
  localparam int WRDI_IDX  = UP_HI + 4;

  disp_state_e      st_q, st_d;
  logic [DP_W-1:0]  sel_q, sel_d;
  logic             a4_q, a4_d;
  logic             in_flash, in_pass, active;

  assign in_flash = (mode_i == MODE_FLASH);
  assign in_pass  = (mode_i == MODE_PASS);
  assign active   = in_flash || in_pass;
  assign accept_o = (st_q == ST_IDLE) && !sel_n_i && active && byte_valid_i;

  always_comb begin
    int ix;
    ix   = int'(idx_i);
    st_d = st_q;
    sel_d = sel_q;
    a4_d = a4_q;
    if (sel_n_i) begin
      st_d  = ST_IDLE;
      sel_d = '0;
      a4_d  = 1'b0;
    end else if (accept_o) begin
      st_d  = ST_WAIT;
      sel_d = '0;
      a4_d  = 1'b0;
      if (hit_i) begin
        if (ix <= STATUS_HI) begin
          if (in_flash || icpt_status_i) begin
            st_d = ST_STATUS; sel_d[DP_STATUS] = 1'b1;
          end
        end else if (ix == ID_IDX) begin
          if (in_flash || icpt_id_i) begin
            st_d = ST_ID; sel_d[DP_ID] = 1'b1;
          end
        end else if (ix == DISC_IDX) begin
          if (in_flash || icpt_disc_i) begin
            st_d = ST_DISC; sel_d[DP_DISC] = 1'b1;
          end
        end else if (ix >= READ_LO && ix <= READ_HI) begin
          st_d = ST_READ; sel_d[DP_READ] = 1'b1;
        end else if (ix >= UP_LO && ix <= UP_HI) begin
          st_d = ST_UPLOAD; sel_d[DP_UPLOAD] = 1'b1;
        end else if (ix == EN4B_IDX) begin
          st_d = ST_ADDR4B; sel_d[DP_EN4B] = 1'b1; a4_d = 1'b1;
        end else if (ix == EX4B_IDX) begin
          st_d = ST_ADDR4B; sel_d[DP_EX4B] = 1'b1;
        end else if (ix == WREN_IDX) begin
          st_d = ST_WREN; sel_d[DP_WREN] = 1'b1;
        end else if (ix == WRDI_IDX) begin
          st_d = ST_WREN; sel_d[DP_WRDI] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sel_q <= '0;
      a4_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
      a4_q  <= a4_d;
    end
  end

  assign dp_sel_o    = sel_q;
  assign addr4b_en_o = a4_q;
endmodule

// File: rtl/opcode_dispatch.sv
module opcode_dispatch
  import dispatch_pkg::*;
#(
  parameter  int NUM_READ   = 5,
  parameter  int NUM_UPLOAD = 2,
  parameter  int OP_W       = 8,
  localparam int NUM_SLOTS  = FIXED_LO_SLOTS + NUM_READ + NUM_UPLOAD + FIXED_HI_SLOTS
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sel_n_i,
  input  logic                      byte_valid_i,
  input  logic [OP_W-1:0]           byte_i,
  input  logic [1:0]                mode_i,
  input  logic                      icpt_status_i,
  input  logic                      icpt_id_i,
  input  logic                      icpt_disc_i,
  input  logic [NUM_SLOTS-1:0]      slot_valid_i,
  input  logic [NUM_SLOTS*OP_W-1:0] slot_opcode_i,
  output logic [DP_W-1:0]           dp_sel_o,
  output logic                      addr4b_en_o,
  output logic                      entry_valid_o,
  output logic [OP_W-1:0]           entry_opcode_o
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [OP_W-1:0]  hit_op;
  logic             accept;
  logic             ent_v_q;
  logic [OP_W-1:0]  ent_op_q;

  slot_match #(
    .NUM_SLOTS (NUM_SLOTS),
    .OP_W      (OP_W),
    .IDX_W     (IDX_W)
  ) i_match (
    .slot_valid_i  (slot_valid_i),
    .slot_opcode_i (slot_opcode_i),
    .byte_i        (byte_i),
    .hit_o         (hit),
    .idx_o         (idx),
    .opcode_o      (hit_op)
  );

  dispatch_fsm #(
    .NUM_READ   (NUM_READ),
    .NUM_UPLOAD (NUM_UPLOAD),
    .IDX_W      (IDX_W)
  ) i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sel_n_i       (sel_n_i),
    .byte_valid_i  (byte_valid_i),
    .mode_i        (mode_i),
    .icpt_status_i (icpt_status_i),
    .icpt_id_i     (icpt_id_i),
    .icpt_disc_i   (icpt_disc_i),
    .hit_i         (hit),
    .idx_i         (idx),
    .accept_o      (accept),
    .dp_sel_o      (dp_sel_o),
    .addr4b_en_o   (addr4b_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_v_q  <= 1'b0;
      ent_op_q <= '0;
    end else if (accept) begin
      ent_v_q  <= hit;
      ent_op_q <= hit ? hit_op : '0;
    end
  end

  assign entry_valid_o  = ent_v_q;
  assign entry_opcode_o = ent_op_q;
endmodule

// File: rtl/dispatch_checker.sv
module dispatch_checker
  import dispatch_pkg::*;
#(
  parameter int OP_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sel_n_i,
  input logic            byte_valid_i,
  input logic [1:0]      mode_i,
  input logic [DP_W-1:0] dp_sel_o,
  input logic            addr4b_en_o,
  input logic            entry_valid_o,
  input logic [OP_W-1:0] entry_opcode_o
);
  logic mode_on;
  assign mode_on = (mode_i == MODE_FLASH) || (mode_i == MODE_PASS);

  assert_sel_known_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(dp_sel_o) && !$isunknown(addr4b_en_o));

  assert_sel_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dp_sel_o));

  assert_clear_on_deselect_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_n_i |=> (dp_sel_o == '0) && !addr4b_en_o);

  assert_sel_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_n_i && dp_sel_o != '0) |=> $stable(dp_sel_o));

  assert_inactive_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_on && dp_sel_o == '0) |=> dp_sel_o == '0);

  assert_flag_en4b_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr4b_en_o |-> dp_sel_o[DP_EN4B]);

  assert_entry_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> $stable(entry_opcode_o) && $stable(entry_valid_o));

  assert_entry_txn_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_n_i && dp_sel_o != '0) |=> $stable(entry_opcode_o) && $stable(entry_valid_o));
endmodule

bind opcode_dispatch dispatch_checker #(.OP_W(OP_W)) i_dispatch_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sel_n_i        (sel_n_i),
  .byte_valid_i   (byte_valid_i),
  .mode_i         (mode_i),
  .dp_sel_o       (dp_sel_o),
  .addr4b_en_o    (addr4b_en_o),
  .entry_valid_o  (entry_valid_o),
  .entry_opcode_o (entry_opcode_o)
);

// File: tb/test_opcode_dispatch.sv
module test_opcode_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           sel_n = 1'b1;
  logic           bv = 1'b0;
  logic [7:0]     bdata = '0;
  logic [1:0]     mode = 2'b01;
  logic [2:0]     icpt = '0;
  logic [NS-1:0]  tb_valid;
  logic [NS*8-1:0] tb_op;
  logic [8:0]     dp_sel;
  logic           a4;
  logic           ev;
  logic [7:0]     eop;

  int n_tests = 0;
  int n_fail = 0;
  logic       m_ev = 1'b0;
  logic [7:0] m_eop = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opcode_dispatch i_opcode_dispatch (
    .clk_i (clk), .rst_ni (rst_n), .sel_n_i (sel_n), .byte_valid_i (bv),
    .byte_i (bdata), .mode_i (mode), .icpt_status_i (icpt[0]),
    .icpt_id_i (icpt[1]), .icpt_disc_i (icpt[2]), .slot_valid_i (tb_valid),
    .slot_opcode_i (tb_op), .dp_sel_o (dp_sel), .addr4b_en_o (a4),
    .entry_valid_o (ev), .entry_opcode_o (eop)
  );

  function automatic logic [7:0] op_of(int i);
    return 8'h21 + 8'(i * 7);
  endfunction

  function automatic int find_slot(logic [7:0] b);
    for (int i = 0; i < NS; i++)
      if (tb_valid[i] && tb_op[i*8 +: 8] == b) return i;
    return -1;
  endfunction

  function automatic logic mode_on(logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  function automatic logic [8:0] model_sel(int s, logic [1:0] m, logic [2:0] ic);
    logic [8:0] r = '0;
    if (!mode_on(m) || s < 0) return r;
    if (s <= 2)       begin if (m == 2'b01 || ic[0]) r[0] = 1'b1; end
    else if (s == 3)  begin if (m == 2'b01 || ic[1]) r[1] = 1'b1; end
    else if (s == 4)  begin if (m == 2'b01 || ic[2]) r[2] = 1'b1; end
    else if (s <= 9)  r[3] = 1'b1;
    else if (s <= 11) r[4] = 1'b1;
    else              r[5 + (s - 12)] = 1'b1;
    return r;
  endfunction

  function automatic string tag_of(int s, logic [1:0] m);
    if (!mode_on(m)) return "R4";
    if (s < 0)       return "R10";
    if (s <= 4)      return (m == 2'b10) ? "R6" : "R5";
    if (s <= 11)     return "R7";
    if (s <= 13)     return "R8";
    return "R9";
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    bv = 1'b1; bdata = b;
    @(negedge clk);
    bv = 1'b0;
  endtask

  task automatic run_txn(logic [7:0] b, string req_override);
    int s;
    logic [8:0] exp;
    string t;
    s = find_slot(b);
    exp = model_sel(s, mode, icpt);
    t = (req_override != "") ? req_override : tag_of(s, mode);
    if (mode_on(mode)) begin
      m_ev  = (s >= 0);
      m_eop = (s >= 0) ? b : 8'h00;
    end
    @(negedge clk);
    sel_n = 1'b0;
    send(b);
    check(t, "select", 32'(dp_sel), 32'(exp));
    check("R8", "4B flag", 32'(a4), 32'(exp[5]));
    check("R11", "entry valid", 32'(ev), 32'(m_ev));
    check("R11", "entry opcode", 32'(eop), 32'(m_eop));
    send(op_of((s + 5) & 15));  // later byte must not re-decode
    check("R10", "select after 2nd byte", 32'(dp_sel), 32'(exp));
    check("R11", "entry after 2nd byte", 32'(eop), 32'(m_eop));
    @(negedge clk);
    sel_n = 1'b1;
    @(negedge clk);
    check("R12", "select after deselect", 32'(dp_sel), 32'h0);
    check("R12", "flag after deselect", 32'(a4), 32'h0);
    send(op_of(3));
    check("R10", "byte while deselected", 32'(dp_sel), 32'h0);
  endtask

  task automatic load_default();
    for (int i = 0; i < NS; i++) begin
      tb_valid[i] = 1'b1;
      tb_op[i*8 +: 8] = op_of(i);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    load_default();
    repeat (3) @(negedge clk);
    check("R1", "reset select", 32'(dp_sel), 32'h0);
    check("R1", "reset flag", 32'(a4), 32'h0);
    check("R1", "reset entry valid", 32'(ev), 32'h0);
    check("R1", "reset entry opcode", 32'(eop), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after release", 32'(dp_sel), 32'h0);

    // full sweep: every mode code, intercept combination, slot and a miss
    for (int m = 0; m < 4; m++) begin
      for (int ic = 0; ic < 8; ic++) begin
        mode = 2'(m);
        icpt = 3'(ic);
        for (int s = 0; s <= NS; s++) begin
          run_txn((s < NS) ? op_of(s) : 8'hF0, "");
        end
      end
    end

    // R2: clear valid bit on slot 3, its opcode must miss
    mode = 2'b01; icpt = '0;
    tb_valid[3] = 1'b0;
    run_txn(op_of(3), "R2");
    tb_valid[3] = 1'b1;

    // R3: duplicate opcode in read slot 6 and upload slot 10
    tb_op[6*8 +: 8]  = 8'h99;
    tb_op[10*8 +: 8] = 8'h99;
    run_txn(8'h99, "R3");
    // R2: clear lower slot, upper one takes over
    tb_valid[6] = 1'b0;
    run_txn(8'h99, "R2");
    load_default();

    // R3: status slot 0 and read slot 8 share an opcode; passthrough, no intercept
    mode = 2'b10; icpt = '0;
    tb_op[8*8 +: 8] = op_of(0);
    run_txn(op_of(0), "R3");
    icpt = 3'b001;
    run_txn(op_of(0), "R3");
    // R3: write-disable slot duplicates en4b opcode; en4b lower index wins
    tb_op[15*8 +: 8] = op_of(12);
    run_txn(op_of(12), "R3");
    load_default();

    summary();
  end
endmodule